// File: doc/BRIEF.md
# Cascadable Bit-Serial Configuration Store

This block is a configuration memory that an FPGA reads one bit per clock while it loads itself in master serial mode. An address counter walks the single-bit array from word 0 upwards. Each selected clock edge moves it one word and presents the next stored bit on the data output, which carries a separate enable so that it can share a line with other devices.

Several stores can be chained. The cascade output of one store drives the chip-enable of the next. When the last word of a store has been read, that store releases the data line and pulls its cascade output low, and the next store starts driving from its own word 0.

A combined reset/output-enable pin clears the counter and quiets the output. A stored polarity bit chooses whether that pin asserts high or low. Pulling the serial-enable pin low enters programming mode: readout is suspended, and a simple word-write port, which stands in for the two-wire programming interface, may load the array and the polarity bit.

Top module: `sercfg_mem`

## Requirements
- R1: After the counter is cleared, the data output presents word 0. Each rising edge on which the store advances presents the next word, in ascending address order, one bit per clock.
- R2: The edge that advances past word DEPTH-1 drives `ceo_n_o` low and deasserts `data_en_o` from then on.
- R3: A store is selected when `ce_n_i` is low. A downstream store whose `ce_n_i` is tied to the upstream `ceo_n_o` drives its word 0 in the first cycle after the handoff. The two stores never drive at the same time.
- R4: While `ce_n_i` is high, `data_en_o` is low and the counter holds its position. On reselection, readout resumes at the word that was due.
- R5: While `rst_oe_i` is at its active level, `data_en_o` is low and `ceo_n_o` returns high, regardless of the other pins. The next edge clears the counter to word 0.
- R6: The polarity bit sets the active level of `rst_oe_i`: 1 means active-high and 0 means active-low. It is written from `prog_bit_i` when `pol_we_i` is high in programming mode.
- R7: While `ser_en_i` is low, `data_en_o` is low and the counter holds. Array writes (`prog_we_i`, `prog_addr_i`, `prog_bit_i`) take effect only in this mode and are ignored while `ser_en_i` is high.
- R8: When `rst_oe_i` stays inactive after the last word, the store remains in the passed-on state: `ceo_n_o` stays low and `data_en_o` stays low for any number of clocks.
- R9: The synchronous `rst` sets the counter to word 0, drives `ceo_n_o` high and loads the polarity bit with POL_INIT (default 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high device reset |
| ce_n_i | input | 1 | Chip enable, active low |
| rst_oe_i | input | 1 | Combined counter reset / output enable; active level set by polarity bit |
| ser_en_i | input | 1 | High: serial read mode; low: programming mode |
| prog_we_i | input | 1 | Array write strobe, honoured in programming mode only |
| pol_we_i | input | 1 | Polarity-bit write strobe, honoured in programming mode only |
| prog_addr_i | input | AW | Array write address, AW = clog2(DEPTH) |
| prog_bit_i | input | 1 | Write data for the array or the polarity bit |
| data_o | output | 1 | Serial data bit (meaningful while data_en_o is high) |
| data_en_o | output | 1 | Data output enable; low means high impedance |
| ceo_n_o | output | 1 | Cascade enable out, active low once the last word is read |

## Verification
The output enable responds to `ce_n_i`, `rst_oe_i` and `ser_en_i` within the same cycle. The data bit and `ceo_n_o` change only on the edge after the stimulus that advances or clears the counter. Inputs are therefore applied shortly after a rising edge, and the scoreboard compares the shared line at the following falling edge. Each expected item is pushed for the cycle whose inputs were just set, so word 0 is due in the first cycle after the clearing cycle. The downstream store's word 0 is due exactly one cycle after the upstream store's last word. Checks of `ceo_n_o` are made once the edge that consumed the last word has passed.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

  // decoded pin state shared between the pin decoder and the counter
  typedef struct packed {
    logic clr;   // counter clear (reset/OE at its active level)
    logic adv;   // selected, not cleared, read mode
    logic prog;  // programming mode
  } sercfg_ctl_t;

endpackage

// File: rtl/sercfg_pin_ctl.sv
module sercfg_pin_ctl #(
  parameter bit POL_INIT = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ce_n_i,
  input  logic                     rst_oe_i,
  input  logic                     ser_en_i,
  input  logic                     pol_we_i,
  input  logic                     prog_bit_i,
  output sercfg_pkg::sercfg_ctl_t  ctl_o
);

  logic pol_q;

  // stored polarity of the reset/OE pin, writable only while programming
  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q <= POL_INIT;
    end else if (!ser_en_i && pol_we_i) begin
      pol_q <= prog_bit_i;
    end
  end

  always_comb begin
    ctl_o.clr  = (rst_oe_i == pol_q);
    ctl_o.prog = !ser_en_i;
    ctl_o.adv  = !ce_n_i && !ctl_o.clr && ser_en_i;
  end

endmodule

// File: rtl/sercfg_addr_ctr.sv
module sercfg_addr_ctr #(
  parameter int DEPTH = 1024,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [AW-1:0] addr_q,
  output logic [AW-1:0] addr_n,
  output logic          passed_q
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic passed_n;

  always_comb begin
    addr_n   = addr_q;
    passed_n = passed_q;
    if (clr_i) begin
      addr_n   = '0;
      passed_n = 1'b0;
    end else if (adv_i && !passed_q) begin
      if (addr_q == LAST) begin
        passed_n = 1'b1;           // saturate on the last word
      end else begin
        addr_n = addr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      passed_q <= 1'b0;
    end else begin
      addr_q   <= addr_n;
      passed_q <= passed_n;
    end
  end

  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !adv_i) |=> ($stable(addr_q) && $stable(passed_q)));

  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (addr_q == '0 && !passed_q));

  assert_saturate_R8: assert property (@(posedge clk) disable iff (rst)
    (passed_q && !clr_i) |=> (passed_q && addr_q == LAST));

endmodule

// File: rtl/sercfg_array.sv
module sercfg_array #(
  parameter int DEPTH = 1024,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic          wbit_i,
  input  logic [AW-1:0] raddr_i,
  output logic          rbit_o
);

  logic mem [DEPTH];

  // single write port, registered read: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we_i && (int'(waddr_i) < DEPTH)) begin
      mem[waddr_i] <= wbit_i;
    end
    rbit_o <= mem[raddr_i];
  end

endmodule

// File: rtl/sercfg_mem.sv
module sercfg_mem #(
  parameter int DEPTH    = 1024,
  parameter bit POL_INIT = 1'b1,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n_i,
  input  logic          rst_oe_i,
  input  logic          ser_en_i,
  input  logic          prog_we_i,
  input  logic          pol_we_i,
  input  logic [AW-1:0] prog_addr_i,
  input  logic          prog_bit_i,
  output logic          data_o,
  output logic          data_en_o,
  output logic          ceo_n_o
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  sercfg_pkg::sercfg_ctl_t ctl;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_n;
  logic          passed_q;
  logic          rbit;

  sercfg_pin_ctl #(.POL_INIT(POL_INIT)) u_pin_ctl (
    .clk        (clk),
    .rst        (rst),
    .ce_n_i     (ce_n_i),
    .rst_oe_i   (rst_oe_i),
    .ser_en_i   (ser_en_i),
    .pol_we_i   (pol_we_i),
    .prog_bit_i (prog_bit_i),
    .ctl_o      (ctl)
  );

  sercfg_addr_ctr #(.DEPTH(DEPTH)) u_addr_ctr (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (ctl.clr),
    .adv_i    (ctl.adv),
    .addr_q   (addr_q),
    .addr_n   (addr_n),
    .passed_q (passed_q)
  );

  // read address follows the next counter value, so data_o always
  // holds the word at the current address one edge later
  sercfg_array #(.DEPTH(DEPTH)) u_array (
    .clk     (clk),
    .we_i    (ctl.prog && prog_we_i),
    .waddr_i (prog_addr_i),
    .wbit_i  (prog_bit_i),
    .raddr_i (addr_n),
    .rbit_o  (rbit)
  );

  assign data_o    = rbit;
  assign data_en_o = ctl.adv && !passed_q;
  assign ceo_n_o   = !passed_q;

  assert_handoff_last_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(passed_q) |-> ($past(addr_q) == LAST));

  assert_standby_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    ce_n_i |-> !data_en_o);

  assert_prog_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !ser_en_i |-> !data_en_o);

  assert_cascade_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !ceo_n_o |-> !data_en_o);

endmodule

// File: tb/sercfg_mem_bench.sv
module sercfg_mem_bench;

  localparam int DEPTH = 40;
  localparam int AW    = $clog2(DEPTH);

  typedef struct {
    bit    drv;
    bit    val;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst, rst_oe, ser_en, ce_a_n, pwe_a, pwe_b, polwe, pbit;
  logic [AW-1:0] paddr;
  logic d_a, en_a, ceo_a_n, d_b, en_b, ceo_b_n;

  exp_t exp_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;

  always #5 clk = ~clk;

  sercfg_mem #(.DEPTH(DEPTH)) u_sercfg_mem (
    .clk(clk), .rst(rst), .ce_n_i(ce_a_n), .rst_oe_i(rst_oe),
    .ser_en_i(ser_en), .prog_we_i(pwe_a), .pol_we_i(polwe),
    .prog_addr_i(paddr), .prog_bit_i(pbit),
    .data_o(d_a), .data_en_o(en_a), .ceo_n_o(ceo_a_n));

  sercfg_mem #(.DEPTH(DEPTH)) u_sercfg_mem_dn (
    .clk(clk), .rst(rst), .ce_n_i(ceo_a_n), .rst_oe_i(rst_oe),
    .ser_en_i(ser_en), .prog_we_i(pwe_b), .pol_we_i(polwe),
    .prog_addr_i(paddr), .prog_bit_i(pbit),
    .data_o(d_b), .data_en_o(en_b), .ceo_n_o(ceo_b_n));

  function automatic bit pat_a(int i);
    return bit'(((i * 5 + 1) / 3) % 2);
  endfunction

  function automatic bit pat_b(int i);
    return (i % 4 == 1) || (i % 7 == 3);
  endfunction

  // monitor: one scoreboard item per cycle, compared at the falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      bit gd, gv;
      e  = exp_q.pop_front();
      gd = en_a || en_b;
      gv = en_a ? d_a : d_b;
      n_chk++;
      if (en_a && en_b) begin
        n_fail++;
        $display("FAIL %s: both stores drive (a=%b b=%b), expected one driver", e.tag, d_a, d_b);
      end else if (gd != e.drv || (gd && gv != e.val)) begin
        n_fail++;
        $display("FAIL %s: line drv=%b val=%b, expected drv=%b val=%b",
                 e.tag, gd, gv, e.drv, e.val);
      end
    end
  end

  // driver: push the expectation for this cycle, then move to the next
  task automatic cyc(input bit drv, input bit val, input string tag);
    exp_t e;
    e.drv = drv; e.val = val; e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk); #2;
  endtask

  task automatic chk(input bit ok, input string tag, input logic act, input logic exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %b, expected %b", tag, act, exp);
    end
  endtask

  // counter clear with the given active level, then release
  task automatic clear_store(input logic act);
    rst_oe = act;
    cyc(1'b0, 1'b0, "R5");
    rst_oe = ~act;
  endtask

  task automatic stream_from(input int first);
    for (int i = first; i < DEPTH; i++) cyc(1'b1, pat_a(i), (i == 5) ? "R7" : "R1");
    for (int i = 0; i < DEPTH; i++)     cyc(1'b1, pat_b(i), (i == 0) ? "R3" : "R1");
    chk(ceo_a_n == 1'b0, "R2", ceo_a_n, 1'b0);
    chk(ceo_b_n == 1'b0, "R2", ceo_b_n, 1'b0);
    for (int k = 0; k < 4; k++) cyc(1'b0, 1'b0, "R8");
    chk(ceo_a_n == 1'b0, "R8", ceo_a_n, 1'b0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout, expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; rst_oe = 1'b0; ser_en = 1'b1; ce_a_n = 1'b0;
    pwe_a = 1'b0; pwe_b = 1'b0; polwe = 1'b0; pbit = 1'b0; paddr = '0;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    // R9: reset state
    chk(ceo_a_n == 1'b1, "R9", ceo_a_n, 1'b1);
    chk(ceo_b_n == 1'b1, "R9", ceo_b_n, 1'b1);

    // R7: programming both arrays, line quiet throughout
    ser_en = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      paddr = AW'(i); pbit = pat_a(i); pwe_a = 1'b1;
      cyc(1'b0, 1'b0, "R7");
    end
    pwe_a = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      paddr = AW'(i); pbit = pat_b(i); pwe_b = 1'b1;
      cyc(1'b0, 1'b0, "R7");
    end
    pwe_b = 1'b0;

    // R7: write in read mode is ignored (word 5 checked in the stream)
    ser_en = 1'b1; rst_oe = 1'b1;
    paddr = AW'(5); pbit = ~pat_a(5); pwe_a = 1'b1;
    cyc(1'b0, 1'b0, "R5");
    pwe_a = 1'b0;

    // R1/R2/R3/R8: full chained stream, active-high reset
    clear_store(1'b1);
    stream_from(0);

    // R5: reset after pass restores the cascade output
    rst_oe = 1'b1;
    cyc(1'b0, 1'b0, "R5");
    chk(ceo_a_n == 1'b1, "R5", ceo_a_n, 1'b1);
    chk(ceo_b_n == 1'b1, "R5", ceo_b_n, 1'b1);
    rst_oe = 1'b0;

    // R4: standby mid-stream, then resume at the due word
    for (int i = 0; i < 10; i++) cyc(1'b1, pat_a(i), "R1");
    ce_a_n = 1'b1;
    for (int k = 0; k < 3; k++) cyc(1'b0, 1'b0, "R4");
    ce_a_n = 1'b0;
    for (int i = 10; i < 15; i++) cyc(1'b1, pat_a(i), "R4");

    // R7: programming mode suspends readout
    ser_en = 1'b0;
    for (int k = 0; k < 2; k++) cyc(1'b0, 1'b0, "R7");
    ser_en = 1'b1;
    for (int i = 15; i < 20; i++) cyc(1'b1, pat_a(i), "R7");

    // R5: reset mid-stream restarts at word 0
    clear_store(1'b1);
    for (int i = 0; i < 8; i++) cyc(1'b1, pat_a(i), "R5");

    // R6: switch to active-low reset
    ser_en = 1'b0; polwe = 1'b1; pbit = 1'b0;
    cyc(1'b0, 1'b0, "R6");
    polwe = 1'b0; ser_en = 1'b1;
    clear_store(1'b0);
    chk(ceo_a_n == 1'b1, "R6", ceo_a_n, 1'b1);
    stream_from(0);
    // R6: low level now clears and releases the chain
    rst_oe = 1'b0;
    cyc(1'b0, 1'b0, "R6");
    chk(ceo_a_n == 1'b1, "R6", ceo_a_n, 1'b1);
    rst_oe = 1'b1;
    cyc(1'b1, pat_a(0), "R6");
    cyc(1'b1, pat_a(1), "R6");

    repeat (2) @(posedge clk);
    summary();
    $finish;
  end

endmodule